// File: doc/BRIEF.md
# Masked interrupt request aggregator

This block gathers eight interrupt request sources into one level-sensitive line for an upstream interrupt router. Each source has a pending bit and an enable bit. Device-side logic raises pending bits by presenting a bit vector on a post input and drops them by presenting a bit vector on a clear input. Either operation can touch any number of bits in a single cycle.

A host byte port reaches three functions through a 2-bit selector: the mask, the pending status, and an acknowledge that retires one request by number. The mask is written active-low, so a 0 in the written byte enables that source. A read of the mask returns the complement of the enable set, which is the byte last written. The upstream line is a registered level. It is high whenever at least one pending bit is also enabled.

Top module: `masked_irq_collector`

## Requirements
- R1: After reset the pending register and the enable set are both zero, `irq_out` is low, a mask read (selector 0) returns 0xFF, and a status read (selector 1) returns 0x00.
- R2: A host write with selector 0 stores the bitwise complement of `host_wdata` as the enable set. From the next cycle, a read with selector 0 returns the byte that was written.
- R3: A read with selector 1 returns the pending register. A read with selector 2 or 3 returns 0x00. `host_rdata` follows the selector combinationally from the registered state.
- R4: Each bit set in `post_vec` sets the matching pending bit at the next clock edge.
- R5: Each bit set in `clr_vec` clears the matching pending bit at the next clock edge.
- R6: A host write with selector 2 clears pending bit N, where N is `host_wdata[3:0]`. The upper nibble is ignored. Values of N from 8 to 15 clear nothing.
- R7: When a post and a clear, or a post and an acknowledge, address the same bit in the same cycle, the bit ends up set.
- R8: `irq_out` is a registered level equal to the OR of (pending AND enable). It reflects any post, clear, acknowledge or mask write at the same clock edge that updates those registers, one cycle after the request.
- R9: Host writes with selector 1 or 3 change neither the pending register nor the enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| post_vec | input | 8 | Device request vector; each 1 sets the matching pending bit |
| clr_vec | input | 8 | Device withdraw vector; each 1 clears the matching pending bit |
| host_we | input | 1 | Host write strobe for the selected function |
| host_sel | input | 2 | Function select: 0 mask, 1 status, 2 acknowledge, 3 unused |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the selected function |
| irq_out | output | 1 | Level request to the upstream router |

## Verification
A corrupted pending or enable bit is visible on `host_rdata` as soon as the host selects the status or mask function. Because reads are combinational, that exposure comes in the same cycle. A wrong pending or enable bit that lines up with its partner also moves `irq_out` one edge later. A wrong bit that is masked stays invisible on the line until a mask write exposes it. For that reason the bench reads both registers back throughout a long mixed run, rather than relying on `irq_out` alone. The riskiest points are the collisions: post against clear, post against acknowledge, and acknowledge numbers above 7. Each of these is driven directly.

// File: rtl/masked_irq_collector.sv
module masked_irq_collector #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] post_vec,
  input  logic [NSRC-1:0] clr_vec,
  input  logic            host_we,
  input  logic [1:0]      host_sel,
  input  logic [7:0]      host_wdata,
  output logic [7:0]      host_rdata,
  output logic            irq_out
);
  localparam logic [1:0] SEL_MASK = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_ACK  = 2'd2;

  logic [NSRC-1:0] pend_q, en_q, pend_d, en_d, ack_hit;
  logic            ack_wr, mask_wr;

  assign ack_wr  = host_we && (host_sel == SEL_ACK);
  assign mask_wr = host_we && (host_sel == SEL_MASK);

  for (genvar i = 0; i < NSRC; i++) begin : g_ack
    assign ack_hit[i] = ack_wr && (host_wdata[3:0] == 4'(i));
  end

  assign en_d   = mask_wr ? ~host_wdata[NSRC-1:0] : en_q;
  assign pend_d = (pend_q & ~clr_vec & ~ack_hit) | post_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      en_q    <= '0;
      irq_out <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      en_q    <= en_d;
      irq_out <= |(pend_d & en_d);
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_sel)
      SEL_MASK: host_rdata[NSRC-1:0] = ~en_q;
      SEL_STAT: host_rdata[NSRC-1:0] = pend_q;
      default:  host_rdata = '0;
    endcase
  end
endmodule

module masked_irq_collector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] post_vec,
  input logic [7:0] clr_vec,
  input logic       host_we,
  input logic [1:0] host_sel,
  input logic [7:0] host_wdata,
  input logic [7:0] pend_q,
  input logic [7:0] en_q,
  input logic       irq_out
);
  always_comb begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (pend_q == 8'h00 && en_q == 8'h00 && !irq_out)
        else $error("reset state wrong");
    end
  end

  p_mask_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel == 2'd0) |=> (en_q == ~$past(host_wdata)));

  p_post_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (post_vec != 8'h00) |=> ((pend_q & $past(post_vec)) == $past(post_vec)));

  p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~post_vec) != 8'h00) |=> ((pend_q & $past(clr_vec & ~post_vec)) == 8'h00));

  p_ack_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel == 2'd2 && !host_wdata[3] && !post_vec[host_wdata[2:0]])
      |=> !pend_q[$past(host_wdata[2:0])]);

  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == |(pend_q & en_q)));

  p_nowrite_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel[0] && post_vec == 8'h00 && clr_vec == 8'h00)
      |=> ($stable(en_q) && $stable(pend_q)));
endmodule

bind masked_irq_collector masked_irq_collector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .post_vec(post_vec), .clr_vec(clr_vec),
  .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
  .pend_q(pend_q), .en_q(en_q), .irq_out(irq_out)
);

// File: tb/test_masked_irq_collector.sv
`timescale 1ns/100ps
module test_masked_irq_collector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] post_vec = '0, clr_vec = '0, host_wdata = '0, host_rdata;
  logic       host_we = 1'b0, irq_out;
  logic [1:0] host_sel = '0;

  int checks = 0, fails = 0;
  int mp = 0, me = 0;
  bit done = 0;

  always #2 clk = ~clk;

  masked_irq_collector i_masked_irq_collector (
    .clk(clk), .rst_n(rst_n), .post_vec(post_vec), .clr_vec(clr_vec),
    .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq_out(irq_out)
  );

  function automatic int exp_read(input int sel);
    if (sel == 0) return (~me) & 8'hFF;
    if (sel == 1) return mp;
    return 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int p, input int c, input bit we, input int sel,
                     input int wd, input string tag);
    int ackm;
    post_vec = 8'(p); clr_vec = 8'(c); host_we = we;
    host_sel = 2'(sel); host_wdata = 8'(wd);
    #1;
    check({tag, " rdata"}, int'(host_rdata), exp_read(sel));
    check({tag, " irq R8"}, int'(irq_out), ((mp & me) != 0) ? 1 : 0);
    ackm = 0;
    if (we && sel == 2 && (wd & 15) < 8) ackm = 1 << (wd & 15);
    if (we && sel == 0) me = (~wd) & 8'hFF;
    mp = ((mp & ~c & ~ackm) | p) & 8'hFF;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, read both registers
    check("R1 mask read", int'(host_rdata), 8'hFF);
    host_sel = 2'd1; #1;
    check("R1 status read", int'(host_rdata), 0);
    check("R1 irq low", int'(irq_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 post while masked, irq stays low
    cyc(8'h81, 0, 0, 1, 0, "R4 post masked");
    cyc(0, 0, 0, 1, 0, "R4 status");
    // R2 enable bit 0 via active-low write
    cyc(0, 0, 1, 0, 8'hFE, "R2 mask write");
    cyc(0, 0, 0, 0, 0, "R2 mask readback R8");
    // R6 ack with upper nibble set, still clears bit 0
    cyc(0, 0, 1, 2, 8'hF0, "R6 ack upper nibble");
    cyc(0, 0, 0, 1, 0, "R6 status after ack");
    // R6 ack number above 7 clears nothing
    cyc(0, 0, 1, 2, 8'h0F, "R6 ack 15");
    cyc(0, 0, 1, 2, 8'h09, "R6 ack 9");
    cyc(0, 0, 0, 1, 0, "R6 status unchanged");
    // R7 post beats ack and clear on same bit
    cyc(8'h01, 0, 1, 2, 8'h00, "R7 post vs ack");
    cyc(8'h02, 8'h02, 0, 1, 0, "R7 post vs clear");
    cyc(0, 0, 0, 1, 0, "R7 status");
    // R5 clear several bits
    cyc(0, 8'h83, 0, 1, 0, "R5 clear");
    cyc(0, 0, 0, 1, 0, "R5 status");
    // R9 writes to status and unused selectors ignored
    cyc(0, 0, 1, 1, 8'hFF, "R9 write sel1");
    cyc(0, 0, 1, 3, 8'h00, "R9 write sel3");
    cyc(0, 0, 0, 0, 0, "R9 mask intact");
    cyc(0, 0, 0, 1, 0, "R9 pend intact");
    // R3 unused read selectors return zero
    cyc(8'h10, 0, 0, 2, 0, "R3 read sel2");
    cyc(0, 0, 0, 3, 0, "R3 read sel3");
    // R8 mask write alone raises and drops irq
    cyc(0, 0, 1, 0, 8'hEF, "R8 enable bit4");
    cyc(0, 0, 0, 1, 0, "R8 irq high");
    cyc(0, 0, 1, 0, 8'hFF, "R8 mask all");
    cyc(0, 0, 0, 1, 0, "R8 irq low");
    // mixed run against the model
    for (int k = 0; k < 3000; k++) begin
      int p, c, wd, sel;
      bit we;
      p   = $urandom & $urandom & $urandom & 8'hFF;
      c   = $urandom & $urandom & 8'hFF;
      wd  = $urandom & 8'hFF;
      sel = $urandom % 4;
      we  = ($urandom % 3) == 0;
      cyc(p, c, we, sel, wd, "R2 R3 R4 R5 R6 R7 R8 R9 mixed");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule